// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block picks one of two unrelated input clocks and forwards it on a single output clock. A typical pairing is a fast clock for active operation and a slow clock for low-power periods. The select input may change at any instant, even in the middle of a high phase. The output never carries a pulse shorter than a full high phase of the source that produced it.

Each source has its own path. That path brings the select request and the other path's enable state into its own clock domain through a rising-edge synchronizer. It then updates a gating enable on its own falling edge, so the enable can only move while that clock is low. A path turns its enable on only once it has seen the other path's enable off. The output is the OR of the two gated clocks.

Each source also has a force-off input. Force-off clears that source's enable at once, with no clock edge needed. This lets the switch leave a clock that has stopped. Two status outputs show which source is driving the output, so software can wait for a handoff to finish before it requests another.

Top module: `clksw_top`

## Requirements
- R1: While rst_n is low, clk_out, active_a and active_b are all held at 0.
- R2: The select input uses 0 for source A and 1 for source B. After reset release with sel at 0, active_a becomes 1 and active_b stays 0.
- R3: active_a and active_b are never 1 at the same time.
- R4: Every high phase of clk_out lasts exactly one full high phase of the source whose status output is 1.
- R5: When the driving source changes, the low interval on clk_out between the last pulse of the old source and the first pulse of the new one is at least half a period of the slower clock.
- R6: After sel changes, the status outputs reach the new selection within (SYNC_STAGES+1) periods of the outgoing clock plus (SYNC_STAGES+1) periods of the incoming clock.
- R7: Outside of force-off and reset, a status output changes only while its own source clock is low.
- R8: A stopped source that is selected keeps its status at 1 after sel moves away. Raising its force-off clears the status immediately, and the other source then takes over when it is selected.
- R9: While a source's force-off is 1, its status stays 0 and clk_out carries none of its pulses.
- R10: After force-off returns to 0, the source resumes driving the output when it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Source clock A |
| clk_b | input | 1 | Source clock B |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through a synchronizer |
| sel | input | 1 | Source request: 0 selects A, 1 selects B |
| force_off_a | input | 1 | Clears the A enable without needing an A edge |
| force_off_b | input | 1 | Clears the B enable without needing a B edge |
| clk_out | output | 1 | Switched output clock |
| active_a | output | 1 | 1 while source A is gated onto the output |
| active_b | output | 1 | 1 while source B is gated onto the output |

## Verification
A select change lands on the status outputs within SYNC_STAGES+1 periods of the outgoing clock plus SYNC_STAGES+1 periods of the incoming clock. With the bench clocks that is under 100 ns, so each status check is made 400 ns after the stimulus. Force-off acts with no register in its path, so the bench samples the status 1 ns after raising it. Pulse width, dead time, mutual exclusion and the phase of every status change are measured on every output edge as it happens, rather than at chosen sample points. The bench moves the select at a different offset within the A period each time, so some changes land in a high phase and some in a low phase.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  localparam int unsigned NUM_SRC = 2;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  // A leg requests the output when the select value names it.
  function automatic logic leg_wants(input src_e leg, input logic sel);
    return sel == logic'(leg);
  endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        chain_q[s] <= RST_VAL;
      end
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clksw_leg.sv
`timescale 1ns/1ps
module clksw_leg #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic force_off,
  input  logic peer_en,
  output logic en,
  output logic gclk
);

  localparam int unsigned IN_W = 3;

  logic            rst_l_n;
  logic            clear_n;
  logic [IN_W-1:0] in_raw;
  logic [IN_W-1:0] in_s;
  logic            want_s;
  logic            peer_off_s;
  logic            force_s;
  logic            en_d;
  logic            en_q;

  // Reset is asserted at once and released on this leg's clock.
  clksw_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_l_n)
  );

  // Request, peer release and force state, brought into this domain.
  assign in_raw = {want, ~peer_en, force_off};

  clksw_sync #(.STAGES(STAGES), .WIDTH(IN_W), .RST_VAL('0)) u_in (
    .clk  (clk),
    .rst_n(rst_l_n),
    .d    (in_raw),
    .q    (in_s)
  );

  assign want_s     = in_s[2];
  assign peer_off_s = in_s[1];
  assign force_s    = in_s[0];

  // Force-off clears the enable with no edge from this clock.
  assign clear_n = rst_l_n & ~force_off;

  always_comb begin
    en_d = en_q;
    if (!want_s || force_s) begin
      en_d = 1'b0;
    end else if (peer_off_s) begin
      en_d = 1'b1;
    end
  end

  // Falling-edge register: the enable only moves while clk is low.
  always_ff @(negedge clk or negedge clear_n) begin
    if (!clear_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign en   = en_q;
  assign gclk = clk & en_q;

  // R3: a fresh grant is only seen while the peer is off.
  p_grant_after_release_r3: assert property (
    @(negedge clk) disable iff (!clear_n)
    $rose(en_q) |-> !peer_en
  );

  // R9: a forced leg never holds its enable.
  p_forced_stays_off_r9: assert property (
    @(negedge clk) disable iff (!rst_l_n)
    force_off |-> !en_q
  );

endmodule

// File: rtl/clksw_merge.sv
`timescale 1ns/1ps
module clksw_merge #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] gclk,
  input  logic [N-1:0] en,
  output logic         clk_out,
  output logic [N-1:0] active
);

  assign clk_out = |gclk;
  assign active  = en;

endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel,
  input  logic force_off_a,
  input  logic force_off_b,
  output logic clk_out,
  output logic active_a,
  output logic active_b
);

  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] force_v;
  logic [NUM_SRC-1:0] en_v;
  logic [NUM_SRC-1:0] gclk_v;
  logic [NUM_SRC-1:0] act_v;

  assign src_clk = {clk_b, clk_a};
  assign force_v = {force_off_b, force_off_a};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
    localparam src_e LEG = src_e'(i);
    logic want;
    assign want = leg_wants(LEG, sel);

    clksw_leg #(.STAGES(SYNC_STAGES)) u_leg (
      .clk      (src_clk[i]),
      .rst_n    (rst_n),
      .want     (want),
      .force_off(force_v[i]),
      .peer_en  (en_v[NUM_SRC-1-i]),
      .en       (en_v[i]),
      .gclk     (gclk_v[i])
    );
  end

  clksw_merge #(.N(NUM_SRC)) u_merge (
    .gclk   (gclk_v),
    .en     (en_v),
    .clk_out(clk_out),
    .active (act_v)
  );

  assign active_a = act_v[SRC_A];
  assign active_b = act_v[SRC_B];

  p_one_hot_a_r3: assert property (
    @(posedge clk_a) disable iff (!rst_n) !(active_a && active_b)
  );

  p_one_hot_b_r3: assert property (
    @(posedge clk_b) disable iff (!rst_n) !(active_a && active_b)
  );

  // R8: force-off clears even when the forced clock gives no edge.
  p_force_clears_a_r8: assert property (
    @(posedge clk_b) disable iff (!rst_n) force_off_a |-> !active_a
  );

  p_force_clears_b_r8: assert property (
    @(posedge clk_a) disable iff (!rst_n) force_off_b |-> !active_b
  );

endmodule

// File: tb/sim_clksw_top.sv
`timescale 1ns/1ps
module sim_clksw_top;

  localparam real HALF_A = 4.0;
  localparam real HALF_B = 10.5;
  localparam real TOL    = 0.01;
  localparam int  NVEC   = 12;
  // {sel, offset in 0.5 ns steps after a rising edge of clk_a}
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 7'd1}, {1'b0, 7'd3}, {1'b1, 7'd6}, {1'b0, 7'd9},
    {1'b1, 7'd12}, {1'b1, 7'd2}, {1'b0, 7'd15}, {1'b1, 7'd4},
    {1'b0, 7'd7}, {1'b1, 7'd0}, {1'b0, 7'd11}, {1'b0, 7'd5}
  };

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic run_a = 1'b1;
  logic rst_n, sel, force_off_a, force_off_b;
  logic clk_out, active_a, active_b;

  int  checks = 0;
  int  errors = 0;
  int  pulses = 0;
  bit  mon_en = 0;
  real t_rise = 0.0, t_fall = 0.0;
  int  last_src = -1, cur_src = 0;

  always #(HALF_A) clk_a = run_a ? ~clk_a : clk_a;
  always #(HALF_B) clk_b = ~clk_b;

  clksw_top u0 (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel),
    .force_off_a(force_off_a), .force_off_b(force_off_b),
    .clk_out(clk_out), .active_a(active_a), .active_b(active_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R4 and R5: every output pulse and every source change is measured.
  always @(posedge clk_out) begin
    pulses++;
    if (mon_en) begin
      cur_src = active_b ? 1 : 0;
      if (last_src >= 0 && cur_src != last_src) begin
        checks++;
        if ($realtime - t_fall < HALF_B - TOL) begin
          errors++;
          $display("FAIL R5 dead time actual %0f expected >= %0f",
                   $realtime - t_fall, HALF_B);
        end
      end
    end
    t_rise = $realtime;
  end

  always @(negedge clk_out) begin
    if (mon_en) begin
      real w, e;
      w = $realtime - t_rise;
      e = cur_src ? HALF_B : HALF_A;
      checks++;
      if (w < e - TOL || w > e + TOL) begin
        errors++;
        $display("FAIL R4 high width actual %0f expected %0f", w, e);
      end
      last_src = cur_src;
      t_fall = $realtime;
    end
  end

  // R3: never both active.
  always @(posedge clk_a or posedge clk_b) begin
    if (mon_en) chk("R3 both active", int'(active_a && active_b), 0);
  end

  // R7: status moves only while its own clock is low.
  always @(active_a) begin
    if (mon_en && !force_off_a) chk("R7 active_a moved with clk_a high", int'(clk_a), 0);
  end
  always @(active_b) begin
    if (mon_en && !force_off_b) chk("R7 active_b moved with clk_b high", int'(clk_b), 0);
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad, p0;
    rst_n = 1'b0; sel = 1'b0; force_off_a = 1'b0; force_off_b = 1'b0;
    bad = 0;
    for (int t = 0; t < 100; t++) begin
      #1;
      if (clk_out !== 1'b0 || active_a !== 1'b0 || active_b !== 1'b0) bad++;
    end
    chk("R1 outputs low in reset", bad, 0);
    #0.3 rst_n = 1'b1;
    mon_en = 1;
    #400;
    chk("R2 active_a after reset", int'(active_a), 1);
    chk("R2 active_b after reset", int'(active_b), 0);

    // Table walk: select changes at many phases of clk_a.
    for (int v = 0; v < NVEC; v++) begin
      @(posedge clk_a);
      #(0.5 * real'(VEC[v][6:0]));
      sel = VEC[v][7];
      #400;
      chk("R6 active_b after select", int'(active_b), int'(VEC[v][7]));
      chk("R6 active_a after select", int'(active_a), int'(!VEC[v][7]));
    end

    // Force-off on the running source B, applied while clk_b is low.
    sel = 1'b1;
    #400;
    chk("R6 active_b before force", int'(active_b), 1);
    @(negedge clk_b);
    #1 force_off_b = 1'b1;
    #1 chk("R8 active_b cleared by force", int'(active_b), 0);
    #100;
    p0 = pulses;
    #300;
    chk("R9 no pulses while B forced", pulses - p0, 0);
    chk("R9 active_b stays low", int'(active_b), 0);
    force_off_b = 1'b0;
    #400;
    chk("R10 active_b resumes", int'(active_b), 1);

    // Stopped source A: stuck without force, left with force.
    sel = 1'b0;
    #400;
    chk("R6 active_a before stop", int'(active_a), 1);
    @(negedge clk_a);
    run_a = 1'b0;
    #20 sel = 1'b1;
    #400;
    chk("R8 stopped A stays active", int'(active_a), 1);
    chk("R8 B waits for stopped A", int'(active_b), 0);
    force_off_a = 1'b1;
    #1 chk("R8 active_a cleared by force", int'(active_a), 0);
    #400;
    chk("R8 B takes over", int'(active_b), 1);

    // A restarts while still forced: it must stay out.
    run_a = 1'b1;
    sel = 1'b0;
    #400;
    p0 = pulses;
    #300;
    chk("R9 no pulses while A forced", pulses - p0, 0);
    chk("R9 active_a stays low", int'(active_a), 0);
    chk("R9 active_b released", int'(active_b), 0);
    force_off_a = 1'b0;
    #400;
    chk("R10 active_a resumes", int'(active_a), 1);
    p0 = pulses;
    #200;
    chk("R10 pulses return", int'(pulses - p0 > 0), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule